// File: doc/BRIEF.md
# Safe Route-Switch and Recovery Sequencer

This block governs every change of signal route in an audio or serial bus bridge, and how the bridge recovers from faults. It does not carry any data itself. It drives the controls around the datapath: the safe-audio mute, an optional clock gate, a FIFO flush strobe, the route select, a relock request and a hard-reset request. It then watches lock, the link's error and slip counters, and the frame boundary marker to decide when the new path can be trusted.

A route request is never applied straight away. The sequencer first silences the output. It then gates the clocks if that variant is built, and flushes the FIFOs. It waits for a frame boundary and changes the select in one step. It holds mute through a verify window of whole frames. Only after that window passes does it release mute. When the link breaks during live streaming, mute rises in the same cycle. A bounded number of relock attempts follow. If they are exhausted, a hard reset is issued and the sequencer waits for the reconfiguration to finish. The active route, the pending route, the last fault reason and the attempt count are all visible at the ports.

Top module: `route_seq`

## Requirements
- R1: After reset, `mute` is 1, `active_route` equals DEF_ROUTE (0), `fault_code` is 0 and `attempts` is 0. Mute stays at 1 until `cfg_done` has been seen and a verify window has then passed. Frame ticks alone do not release it.
- R2: After a request, mute rises in the first sequence cycle. `clk_gate` rises in the next cycle. `fifo_flush` is then a pulse of exactly one cycle. All of these happen while mute is 1.
- R3: `active_route` changes only in the cycle after a `frame_tick` seen in the align step. It goes directly to the requested value, with mute high before and after the change.
- R4: Mute is released only after VERIFY_FRAMES (4) frame ticks during which lock stays 1 and `err_cnt` and `slip_cnt` stay unchanged. Any violation ends the window and starts a relock.
- R5: Each relock shows `relock_req` for one cycle and raises `attempts` by one. `attempts` never exceeds MAX_RETRY (2). A verify failure at MAX_RETRY issues a one-cycle `hard_reset` and sets `fault_code` 6. The sequencer then keeps mute at 1 until `cfg_done`.
- R6: During live streaming, lock loss, `crc_storm`, `fifo_under` or `fifo_over` raises mute in the same cycle. A relock follows with `attempts` = 1. `fault_code` records the fault as lock 1, CRC storm 2, underflow 3 or overflow 4. When several faults are present together, the lowest code number wins.
- R7: If no frame tick arrives within TMO_FRAMES*FRAME_CYC (48) cycles of the align step, the sequencer drops the request and sets `fault_code` 5. The route is left unchanged and a relock follows.
- R8: A request that arrives mid-sequence is queued. While a sequence runs, `pending_route` shows the route in progress, and the queued route starts its own sequence once the current one ends. `pending_valid` is 1 whenever a route is queued or in progress.
- R9: `clk_gate` is 1 from the gate step through the align step only. It is 0 again once verification starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Route request strobe |
| req_route | input | RW | Requested route |
| frame_tick | input | 1 | Frame boundary / alignment marker |
| lock | input | 1 | Link lock status |
| err_cnt | input | CW | Link error counter |
| slip_cnt | input | CW | Frame slip counter |
| crc_storm | input | 1 | CRC storm fault |
| fifo_under | input | 1 | FIFO underflow fault |
| fifo_over | input | 1 | FIFO overflow fault |
| cfg_done | input | 1 | Reconfiguration finished |
| mute | output | 1 | Safe-audio control |
| clk_gate | output | 1 | Stream clock gate |
| fifo_flush | output | 1 | FIFO flush strobe |
| relock_req | output | 1 | Relock attempt strobe |
| hard_reset | output | 1 | Hard reset strobe |
| active_route | output | RW | Route select in force |
| pending_route | output | RW | Route in progress or queued |
| pending_valid | output | 1 | A route is in progress or queued |
| fault_code | output | 3 | Last fault reason |
| attempts | output | clog2(MAX_RETRY+1) | Relock attempt count |

## Verification
The bench first runs a clean switch and times every control step to the cycle. This separates the ordering of mute, gate and flush from the frame-aligned select change. It then disturbs the verify window in two ways. A single error-counter step must recover after one relock. Persistent lock loss must walk the relock count up to its limit and end in a hard reset. Each fault input is applied alone and in combination, to separate the reason-code priority from the immediate mute. A missing frame boundary and a request issued in mid-sequence show that a timeout drops a route while a queued request is honoured.

// File: rtl/route_seq_pkg.sv
package route_seq_pkg;

    typedef enum logic [3:0] {
        ST_CFG,
        ST_LIVE,
        ST_MUTE,
        ST_GATE,
        ST_FLUSH,
        ST_ALIGN,
        ST_VERIFY,
        ST_RELOCK,
        ST_HRST
    } seq_state_t;

    typedef enum logic [2:0] {
        RC_NONE    = 3'd0,
        RC_LOCK    = 3'd1,
        RC_CRC     = 3'd2,
        RC_UNDER   = 3'd3,
        RC_OVER    = 3'd4,
        RC_TIMEOUT = 3'd5,
        RC_VERIFY  = 3'd6
    } reason_t;

endpackage

// File: rtl/rs_timer.sv
// Counts cycles while run is high; flags the last allowed cycle.
module rs_timer #(
    parameter int LIMIT = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (cnt != TW'(LIMIT - 1))
            cnt <= cnt + 1'b1;
    end

    assign expire = run && (cnt == TW'(LIMIT - 1));
endmodule

// File: rtl/rs_verify.sv
// Verify window: snapshots the counters while idle, then requires FRAMES
// clean frame ticks with lock held and both counters unchanged.
module rs_verify #(
    parameter int CW     = 8,
    parameter int FRAMES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          frame_tick,
    input  logic          lock,
    input  logic [CW-1:0] err_cnt,
    input  logic [CW-1:0] slip_cnt,
    input  logic          bad_evt,
    output logic          pass,
    output logic          fail
);
    localparam int FW = $clog2(FRAMES + 1);

    logic [CW-1:0] snap_err, snap_slip;
    logic [FW-1:0] fcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_err  <= '0;
            snap_slip <= '0;
            fcnt      <= '0;
        end else if (!run) begin
            snap_err  <= err_cnt;
            snap_slip <= slip_cnt;
            fcnt      <= '0;
        end else if (frame_tick) begin
            fcnt <= fcnt + 1'b1;
        end
    end

    assign fail = run && (!lock || bad_evt ||
                          (err_cnt != snap_err) || (slip_cnt != snap_slip));
    assign pass = run && !fail && frame_tick && (fcnt == FW'(FRAMES - 1));
endmodule

// File: rtl/route_seq.sv
module route_seq
    import route_seq_pkg::*;
#(
    parameter int              RW            = 2,
    parameter int              CW            = 8,
    parameter logic [RW-1:0]   DEF_ROUTE     = '0,
    parameter bit              GATE_CLK      = 1'b1,
    parameter int              VERIFY_FRAMES = 4,
    parameter int              MAX_RETRY     = 2,
    parameter int              FRAME_CYC     = 16,
    parameter int              TMO_FRAMES    = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic [RW-1:0]                  req_route,
    input  logic                           frame_tick,
    input  logic                           lock,
    input  logic [CW-1:0]                  err_cnt,
    input  logic [CW-1:0]                  slip_cnt,
    input  logic                           crc_storm,
    input  logic                           fifo_under,
    input  logic                           fifo_over,
    input  logic                           cfg_done,
    output logic                           mute,
    output logic                           clk_gate,
    output logic                           fifo_flush,
    output logic                           relock_req,
    output logic                           hard_reset,
    output logic [RW-1:0]                  active_route,
    output logic [RW-1:0]                  pending_route,
    output logic                           pending_valid,
    output logic [2:0]                     fault_code,
    output logic [$clog2(MAX_RETRY+1)-1:0] attempts
);
    localparam int AW      = $clog2(MAX_RETRY + 1);
    localparam int TMO_CYC = FRAME_CYC * TMO_FRAMES;

    seq_state_t     state, nxt;
    reason_t        code_q, code_now;
    logic [RW-1:0]  route_q, tgt_q, q_route;
    logic           q_v;
    logic [AW-1:0]  att_q;
    logic           fault_any, bad_evt, tmo, v_pass, v_fail, in_seq, gate_w;

    assign bad_evt   = crc_storm || fifo_under || fifo_over;
    assign fault_any = !lock || bad_evt;
    assign in_seq    = state inside {ST_MUTE, ST_GATE, ST_FLUSH, ST_ALIGN};

    rs_timer #(.LIMIT(TMO_CYC)) u_tmo (
        .clk(clk), .rst_n(rst_n), .run(state == ST_ALIGN), .expire(tmo)
    );

    rs_verify #(.CW(CW), .FRAMES(VERIFY_FRAMES)) u_ver (
        .clk(clk), .rst_n(rst_n), .run(state == ST_VERIFY),
        .frame_tick(frame_tick), .lock(lock), .err_cnt(err_cnt),
        .slip_cnt(slip_cnt), .bad_evt(bad_evt), .pass(v_pass), .fail(v_fail)
    );

    // Fault priority: lock, CRC storm, underflow, overflow
    always_comb begin
        if (!lock)           code_now = RC_LOCK;
        else if (crc_storm)  code_now = RC_CRC;
        else if (fifo_under) code_now = RC_UNDER;
        else                 code_now = RC_OVER;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CFG;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_CFG:    if (cfg_done) nxt = ST_VERIFY;
            ST_LIVE:   if (fault_any) nxt = ST_RELOCK;
                       else if (q_v)  nxt = ST_MUTE;
            ST_MUTE:   nxt = GATE_CLK ? ST_GATE : ST_FLUSH;
            ST_GATE:   nxt = ST_FLUSH;
            ST_FLUSH:  nxt = ST_ALIGN;
            ST_ALIGN:  if (frame_tick) nxt = ST_VERIFY;
                       else if (tmo)   nxt = ST_RELOCK;
            ST_VERIFY: if (v_fail) nxt = (att_q < AW'(MAX_RETRY)) ? ST_RELOCK : ST_HRST;
                       else if (v_pass) nxt = ST_LIVE;
            ST_RELOCK: nxt = ST_VERIFY;
            ST_HRST:   nxt = ST_CFG;
            default:   nxt = ST_CFG;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_q <= DEF_ROUTE;
            tgt_q   <= DEF_ROUTE;
            q_route <= DEF_ROUTE;
            q_v     <= 1'b0;
            att_q   <= '0;
            code_q  <= RC_NONE;
        end else begin
            if (req_valid) begin
                q_v     <= 1'b1;
                q_route <= req_route;
            end else if (state == ST_LIVE && !fault_any && q_v) begin
                q_v <= 1'b0;
            end
            unique case (state)
                ST_LIVE:
                    if (fault_any) begin
                        code_q <= code_now;
                        att_q  <= AW'(1);
                    end else if (q_v) begin
                        tgt_q <= q_route;
                        att_q <= '0;
                    end
                ST_ALIGN:
                    if (frame_tick) begin
                        route_q <= tgt_q;
                    end else if (tmo) begin
                        code_q <= RC_TIMEOUT;
                        att_q  <= AW'(1);
                    end
                ST_VERIFY:
                    if (v_fail) begin
                        if (att_q < AW'(MAX_RETRY)) att_q  <= att_q + 1'b1;
                        else                         code_q <= RC_VERIFY;
                    end
                default: ;
            endcase
        end
    end

    generate
        if (GATE_CLK) begin : g_gate
            assign gate_w = state inside {ST_GATE, ST_FLUSH, ST_ALIGN};
        end else begin : g_nogate
            assign gate_w = 1'b0;
        end
    endgenerate

    always_comb begin
        mute          = (state != ST_LIVE) || fault_any;
        clk_gate      = gate_w;
        fifo_flush    = (state == ST_FLUSH);
        relock_req    = (state == ST_RELOCK);
        hard_reset    = (state == ST_HRST);
        active_route  = route_q;
        pending_route = in_seq ? tgt_q : q_route;
        pending_valid = q_v || in_seq;
        fault_code    = code_q;
        attempts      = att_q;
    end
endmodule

// File: rtl/rs_chk.sv
module rs_chk #(
    parameter int RW        = 2,
    parameter int MAX_RETRY = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           frame_tick,
    input logic                           lock,
    input logic                           mute,
    input logic                           clk_gate,
    input logic                           fifo_flush,
    input logic                           hard_reset,
    input logic [RW-1:0]                  active_route,
    input logic [$clog2(MAX_RETRY+1)-1:0] attempts
);
    assert_route_on_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(active_route) |-> $past(frame_tick) && mute && $past(mute));

    assert_flush_muted_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |-> mute && $past(mute));

    assert_flush_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |=> !fifo_flush);

    assert_unmute_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mute) |-> $past(lock) && $past(frame_tick));

    assert_attempt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(attempts) <= MAX_RETRY);

    assert_escalate_at_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hard_reset) |-> int'(attempts) == MAX_RETRY);

    assert_lockloss_mutes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !lock |=> mute);

    assert_gate_muted_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clk_gate |-> mute);
endmodule

bind route_seq rs_chk #(.RW(RW), .MAX_RETRY(MAX_RETRY)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .lock(lock),
    .mute(mute), .clk_gate(clk_gate), .fifo_flush(fifo_flush),
    .hard_reset(hard_reset), .active_route(active_route), .attempts(attempts)
);

// File: tb/sim_route_seq.sv
`timescale 1ns/1ps
module sim_route_seq;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       req_valid = 0;
    logic [1:0] req_route = 0;
    logic       frame_tick = 0;
    logic       lock = 1;
    logic [7:0] err_cnt = 0;
    logic [7:0] slip_cnt = 0;
    logic       crc_storm = 0, fifo_under = 0, fifo_over = 0, cfg_done = 0;
    logic       mute, clk_gate, fifo_flush, relock_req, hard_reset, pending_valid;
    logic [1:0] active_route, pending_route, attempts;
    logic [2:0] fault_code;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    route_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_route(req_route),
        .frame_tick(frame_tick), .lock(lock), .err_cnt(err_cnt), .slip_cnt(slip_cnt),
        .crc_storm(crc_storm), .fifo_under(fifo_under), .fifo_over(fifo_over),
        .cfg_done(cfg_done), .mute(mute), .clk_gate(clk_gate), .fifo_flush(fifo_flush),
        .relock_req(relock_req), .hard_reset(hard_reset), .active_route(active_route),
        .pending_route(pending_route), .pending_valid(pending_valid),
        .fault_code(fault_code), .attempts(attempts)
    );

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk); frame_tick = 1;
        @(negedge clk); frame_tick = 0;
    endtask

    task automatic pass_window();
        for (int i = 0; i < 3; i++) tick();
        check("R4", "mute before window ends", mute, 1);
        tick();
        check("R4", "mute after clean window", mute, 0);
    endtask

    task automatic go_align(logic [1:0] r);
        @(negedge clk); req_valid = 1; req_route = r;
        @(negedge clk); req_valid = 0;
        step(4);
    endtask

    task automatic t_reset();
        rst_n = 0; step(3); rst_n = 1; step(2);
        check("R1", "mute after reset", mute, 1);
        check("R1", "default route", active_route, 0);
        check("R1", "fault code", fault_code, 0);
        check("R1", "attempts", attempts, 0);
        tick(); tick();
        check("R1", "mute held without cfg_done", mute, 1);
        @(negedge clk); cfg_done = 1;
        @(negedge clk); cfg_done = 0;
        pass_window();
    endtask

    task automatic t_switch();
        @(negedge clk); req_valid = 1; req_route = 2;
        @(negedge clk); req_valid = 0;
        check("R8", "queued valid", pending_valid, 1);
        check("R8", "queued route", pending_route, 2);
        check("R2", "mute before sequence", mute, 0);
        @(negedge clk);
        check("R2", "mute first", mute, 1);
        check("R2", "gate not yet", clk_gate, 0);
        check("R2", "flush not yet", fifo_flush, 0);
        @(negedge clk);
        check("R2", "gate second", clk_gate, 1);
        check("R2", "flush not in gate step", fifo_flush, 0);
        @(negedge clk);
        check("R2", "flush pulse", fifo_flush, 1);
        @(negedge clk);
        check("R2", "flush single cycle", fifo_flush, 0);
        check("R9", "gate held in align", clk_gate, 1);
        step(5);
        check("R3", "no change without frame tick", active_route, 0);
        tick();
        check("R3", "route at frame tick", active_route, 2);
        check("R3", "muted across switch", mute, 1);
        check("R9", "gate dropped in verify", clk_gate, 0);
        pass_window();
        check("R8", "nothing pending", pending_valid, 0);
        check("R5", "attempts clean switch", attempts, 0);
    endtask

    task automatic t_verify_retry();
        go_align(1);
        tick(); tick();
        @(negedge clk); err_cnt = 5;
        @(negedge clk);
        check("R4", "relock on counter change", relock_req, 1);
        check("R5", "attempts after one relock", attempts, 1);
        check("R4", "still muted", mute, 1);
        pass_window();
        check("R3", "route kept", active_route, 1);
    endtask

    task automatic t_escalate();
        @(negedge clk); lock = 0; #1;
        check("R6", "lock loss mutes same cycle", mute, 1);
        @(negedge clk);
        check("R5", "relock 1", relock_req, 1);
        check("R5", "attempts 1", attempts, 1);
        check("R6", "code lock", fault_code, 1);
        @(negedge clk);
        check("R5", "relock pulse one cycle", relock_req, 0);
        @(negedge clk);
        check("R5", "relock 2", relock_req, 1);
        check("R5", "attempts 2", attempts, 2);
        @(negedge clk);
        @(negedge clk);
        check("R5", "hard reset issued", hard_reset, 1);
        check("R5", "attempts capped", attempts, 2);
        check("R5", "code verify exhausted", fault_code, 6);
        @(negedge clk);
        check("R5", "hard reset one cycle", hard_reset, 0);
        lock = 1;
        tick(); tick();
        check("R5", "muted until cfg_done", mute, 1);
        @(negedge clk); cfg_done = 1;
        @(negedge clk); cfg_done = 0;
        pass_window();
        check("R5", "route kept over reset", active_route, 1);
    endtask

    task automatic fault_case(logic l, logic c, logic u, logic o, int code);
        @(negedge clk); lock = l; crc_storm = c; fifo_under = u; fifo_over = o; #1;
        check("R6", "fault mutes same cycle", mute, 1);
        @(negedge clk); lock = 1; crc_storm = 0; fifo_under = 0; fifo_over = 0;
        check("R6", "fault code", fault_code, code);
        check("R6", "relock started", relock_req, 1);
        check("R6", "attempts", attempts, 1);
        pass_window();
    endtask

    task automatic t_faults();
        fault_case(1, 1, 0, 0, 2);
        fault_case(1, 0, 1, 0, 3);
        fault_case(1, 0, 0, 1, 4);
        fault_case(1, 1, 0, 1, 2);
        fault_case(0, 1, 1, 0, 1);
    endtask

    task automatic t_timeout();
        go_align(3);
        step(60);
        check("R7", "timeout code", fault_code, 5);
        check("R7", "route unchanged", active_route, 1);
        check("R7", "request dropped", pending_valid, 0);
        check("R7", "muted", mute, 1);
        pass_window();
        check("R7", "attempts after timeout", attempts, 1);
        check("R7", "route still", active_route, 1);
    endtask

    task automatic t_queue();
        go_align(2);
        @(negedge clk); req_valid = 1; req_route = 3;
        @(negedge clk); req_valid = 0;
        check("R8", "in-progress route shown", pending_route, 2);
        check("R8", "pending valid", pending_valid, 1);
        tick();
        check("R8", "current target applied", active_route, 2);
        for (int i = 0; i < 4; i++) tick();
        check("R8", "first route live", active_route, 2);
        @(negedge clk);
        check("R8", "queued sequence started", mute, 1);
        check("R8", "queued route shown", pending_route, 3);
        step(3);
        tick();
        check("R8", "queued route applied", active_route, 3);
        pass_window();
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_switch();
        t_verify_retry();
        t_escalate();
        t_faults();
        t_timeout();
        t_queue();
        summary();
        $finish;
    end
endmodule